// File: doc/BRIEF.md
# Atomic Snooping Bus Hub with Memory Controller

This block is the shared, atomic coherence bus for a group of cache controllers, together with a small main memory that sits behind it. Caches raise requests and the hub picks one in round-robin order. It broadcasts that transaction to every snooper. It then decides where the reply data comes from: a snooper that holds the line dirty and flushes it, or memory when no cache intervenes. Only one transaction is in flight at a time, so the order in which transactions appear on the snoop channel is the single global order that every cache observes.

Each cache's request channel is a valid/ready pair. `req_valid` is the valid and `grant` is the ready. A requester holds `req_valid` and its command, address and write data steady until it sees its `grant` bit. It may then drop the request. If it keeps the request high after the grant, the hub treats that as a new request. Requests are only taken while the bus is idle. The grant stays high until the transaction completes. The reply channel has no back-pressure: `rsp_valid` is a one-cycle broadcast that the granted cache must accept. Snoopers answer on `snp_flush`/`snp_fdata` in the cycle right after the broadcast.

Top module: `snoop_bus_hub`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant` is all zero and `snp_valid`, `rsp_valid` and `txn_done` are low. Main memory reads as zero at every address.
- R2: At most one `grant` bit is high at a time. Once a grant rises, it stays unchanged until the cycle in which `txn_done` is high. It falls in the following cycle.
- R3: Arbitration is round-robin. Among the requesters present in an idle cycle, the winner is the first index after the last granted cache, counting upward and wrapping. Cache 0 is favoured first after reset.
- R4: Commands are encoded 0 = shared read, 1 = read for ownership, 2 = upgrade (invalidate only), 3 = writeback. In the cycle after a request is accepted, `snp_valid` is high for exactly one cycle. It carries the winner's command on `snp_cmd`, its address on `snp_addr` and its index on `snp_src`, and the winner's `grant` bit rises in that same cycle.
- R5: For commands 0 and 1, the hub samples `snp_flush` in the cycle after the broadcast. If no other cache flushes, `rsp_valid` and `txn_done` are high in the next cycle, with `rsp_data` equal to memory at the address and `rsp_from_cache` low.
- R6: For commands 0 and 1, when a cache other than the requester asserts `snp_flush` in the sampling cycle, `rsp_data` carries that cache's `snp_fdata` and `rsp_from_cache` is high. Memory at the address takes the same value in the same transaction.
- R7: A `snp_flush` asserted by the requesting cache itself is ignored. The reply comes from memory and memory is unchanged.
- R8: Command 2 finishes with no data phase. `txn_done` is high in the sampling cycle, `rsp_valid` never rises, and memory is neither read for a reply nor written, even when a snooper flushes.
- R9: Command 3 writes the requester's `req_wdata` into memory at the address. `txn_done` is high in the sampling cycle, `rsp_valid` stays low, and snoop flushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CACHE | Per-cache request valid |
| req_cmd | input | 2*N_CACHE | Per-cache command, 2 bits per cache |
| req_addr | input | ADDR_W*N_CACHE | Per-cache line address |
| req_wdata | input | DATA_W*N_CACHE | Per-cache writeback data |
| grant | output | N_CACHE | Per-cache grant (ready), held for the whole transaction |
| snp_valid | output | 1 | Snoop broadcast strobe |
| snp_cmd | output | 2 | Broadcast command |
| snp_addr | output | ADDR_W | Broadcast address |
| snp_src | output | $clog2(N_CACHE) | Index of the requesting cache |
| snp_flush | input | N_CACHE | Per-snooper flush (intervention) response |
| snp_fdata | input | DATA_W*N_CACHE | Per-snooper flushed line data |
| rsp_valid | output | 1 | Reply data strobe to the requester |
| rsp_data | output | DATA_W | Reply data |
| rsp_from_cache | output | 1 | High when the reply came from a flushing cache |
| txn_done | output | 1 | Transaction complete pulse |

## Verification
The bench aims at the reply-source decision. It mixes flushes from a third cache, from the requester itself, and from no cache at all. A hub that picked the wrong source would return stale memory data or the wrong cache's data. It also checks that memory is updated on interventions and writebacks by reading the address back later. A hub that dropped the write-through on a flush, or that wrote memory during an upgrade, would show a wrong value at that later read. Simultaneous requests from several caches check the round-robin order. An arbiter that ignored its last-served pointer would serve the same low index twice.

// File: rtl/snb_pkg.sv
package snb_pkg;
  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_RDX  = 2'd1,
    CMD_UPGR = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_SNOOP = 2'd2,
    ST_DATA  = 2'd3
  } bus_state_e;
endpackage

// File: rtl/snb_rr_arbiter.sv
module snb_rr_arbiter #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             take,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  logic [IDX_W-1:0] last_q;

  // scan from highest offset to lowest so the nearest index after last_q wins
  always_comb begin
    int idx;
    any = 1'b0;
    win = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(last_q) + 1 + k) % N;
      if (req[idx]) begin
        any = 1'b1;
        win = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IDX_W'(N - 1);
    else if (take && any) last_q <= win;
  end
endmodule

// File: rtl/snb_mem.sv
module snb_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  assign rdata = cells[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/snoop_bus_hub.sv
module snoop_bus_hub
  import snb_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  localparam int SRC_W  = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CACHE-1:0]        req_valid,
  input  logic [2*N_CACHE-1:0]      req_cmd,
  input  logic [ADDR_W*N_CACHE-1:0] req_addr,
  input  logic [DATA_W*N_CACHE-1:0] req_wdata,
  output logic [N_CACHE-1:0]        grant,
  output logic                      snp_valid,
  output logic [1:0]                snp_cmd,
  output logic [ADDR_W-1:0]         snp_addr,
  output logic [SRC_W-1:0]          snp_src,
  input  logic [N_CACHE-1:0]        snp_flush,
  input  logic [DATA_W*N_CACHE-1:0] snp_fdata,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_data,
  output logic                      rsp_from_cache,
  output logic                      txn_done
);
  bus_state_e        state_q;
  logic [SRC_W-1:0]  owner_q;
  bus_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              from_cache_q;

  logic              arb_any;
  logic [SRC_W-1:0]  arb_win;
  logic              take;

  logic [N_CACHE-1:0] flush_other;
  logic               hit;
  logic [DATA_W-1:0]  fdata_sel;
  logic               is_read;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_wdata;
  logic [DATA_W-1:0]  mem_rdata;

  assign take = (state_q == ST_IDLE);

  snb_rr_arbiter #(.N(N_CACHE), .IDX_W(SRC_W)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_valid),
    .take (take),
    .any  (arb_any),
    .win  (arb_win)
  );

  // intervention data: flushes from the requester itself are masked out
  assign flush_other = snp_flush & ~(N_CACHE'(1) << owner_q);
  assign hit         = |flush_other;

  always_comb begin
    fdata_sel = '0;
    for (int i = 0; i < N_CACHE; i++)
      if (flush_other[i]) fdata_sel = fdata_sel | snp_fdata[i*DATA_W +: DATA_W];
  end

  assign is_read   = (cmd_q == CMD_RD) || (cmd_q == CMD_RDX);
  assign mem_we    = (state_q == ST_SNOOP) && ((is_read && hit) || (cmd_q == CMD_WB));
  assign mem_wdata = (cmd_q == CMD_WB) ? wdata_q : fdata_sel;

  snb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(addr_q),
    .wdata(mem_wdata),
    .raddr(addr_q),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      owner_q      <= '0;
      cmd_q        <= CMD_RD;
      addr_q       <= '0;
      wdata_q      <= '0;
      rsp_data_q   <= '0;
      from_cache_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arb_any) begin
          owner_q <= arb_win;
          cmd_q   <= bus_cmd_e'(req_cmd[int'(arb_win)*2 +: 2]);
          addr_q  <= req_addr[int'(arb_win)*ADDR_W +: ADDR_W];
          wdata_q <= req_wdata[int'(arb_win)*DATA_W +: DATA_W];
          state_q <= ST_ADDR;
        end
        ST_ADDR: state_q <= ST_SNOOP;
        ST_SNOOP: begin
          if (is_read) begin
            rsp_data_q   <= hit ? fdata_sel : mem_rdata;
            from_cache_q <= hit;
            state_q      <= ST_DATA;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DATA: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign grant          = (state_q != ST_IDLE) ? (N_CACHE'(1) << owner_q) : '0;
  assign snp_valid      = (state_q == ST_ADDR);
  assign snp_cmd        = cmd_q;
  assign snp_addr       = addr_q;
  assign snp_src        = owner_q;
  assign rsp_valid      = (state_q == ST_DATA);
  assign rsp_data       = rsp_data_q;
  assign rsp_from_cache = from_cache_q;
  assign txn_done       = (state_q == ST_DATA) || ((state_q == ST_SNOOP) && !is_read);
endmodule

// File: rtl/snb_checker.sv
module snb_checker #(
  parameter int N_CACHE = 4,
  parameter int SRC_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CACHE-1:0] grant,
  input logic               snp_valid,
  input logic [1:0]         snp_cmd,
  input logic [SRC_W-1:0]   snp_src,
  input logic               rsp_valid,
  input logic               txn_done
);
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && !txn_done) |=> (grant == $past(grant)));

  a_r2_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> (grant == '0));

  a_r4_snoop_single: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !snp_valid);

  a_r4_snoop_owner: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> grant[snp_src]);

  a_r5_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(snp_valid, 2));

  a_r8_upgr_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd2) |=> (txn_done && !rsp_valid) ##1 !rsp_valid);

  a_r9_wb_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd3) |=> (txn_done && !rsp_valid) ##1 !rsp_valid);
endmodule

bind snoop_bus_hub snb_checker #(.N_CACHE(N_CACHE), .SRC_W(SRC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant    (grant),
  .snp_valid(snp_valid),
  .snp_cmd  (snp_cmd),
  .snp_src  (snp_src),
  .rsp_valid(rsp_valid),
  .txn_done (txn_done)
);

// File: tb/tb_snoop_bus_hub.sv
`timescale 1ns/1ps
module tb_snoop_bus_hub;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_cmd = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    grant;
  logic            snp_valid;
  logic [1:0]      snp_cmd;
  logic [AW-1:0]   snp_addr;
  logic [SW-1:0]   snp_src;
  logic [N-1:0]    snp_flush = '0;
  logic [DW*N-1:0] snp_fdata = '0;
  logic            rsp_valid;
  logic [DW-1:0]   rsp_data;
  logic            rsp_from_cache;
  logic            txn_done;

  int checks = 0;
  int errors = 0;
  int last_srv = N - 1;
  bit finished = 1'b0;
  logic [DW-1:0] mem_m [1 << AW];

  always #2.5 clk = ~clk;

  snoop_bus_hub #(.N_CACHE(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_src(snp_src), .snp_flush(snp_flush), .snp_fdata(snp_fdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_from_cache(rsp_from_cache), .txn_done(txn_done)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rr_next(int last, logic [N-1:0] mask);
    for (int k = 1; k <= N; k++) begin
      if (mask[(last + k) % N]) return (last + k) % N;
    end
    return -1;
  endfunction

  function automatic bit is_read(logic [1:0] c);
    return (c == 2'd0) || (c == 2'd1);
  endfunction

  task automatic wait_grant();
    int guard = 0;
    while (grant == '0 && guard < 50) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // one transaction from a lone requester; flusher < 0 means no snooper flushes
  task automatic do_txn(int src, logic [1:0] cmd, int addr, logic [DW-1:0] wd,
                        int flusher, logic [DW-1:0] fd);
    logic [DW-1:0] exp_d;
    bit exp_fc;
    @(negedge clk);
    req_valid[src] = 1'b1;
    req_cmd[src*2 +: 2] = cmd;
    req_addr[src*AW +: AW] = AW'(addr);
    req_wdata[src*DW +: DW] = wd;
    @(negedge clk);
    wait_grant();
    chk(grant == (N'(1) << src), "R4", "grant of requester", 32'(grant), 32'(N'(1) << src));
    chk(snp_valid && snp_cmd == cmd && snp_addr == AW'(addr) && int'(snp_src) == src,
        "R4", "snoop broadcast", {snp_valid, 5'd0, snp_cmd, 2'd0, snp_addr, 14'd0, snp_src},
        {1'b1, 5'd0, cmd, 2'd0, AW'(addr), 14'd0, SW'(src)});
    req_valid[src] = 1'b0;
    last_srv = src;
    @(negedge clk);
    chk(!snp_valid, "R4", "broadcast single cycle", 32'(snp_valid), 32'd0);
    if (flusher >= 0) begin
      snp_flush[flusher] = 1'b1;
      snp_fdata[flusher*DW +: DW] = fd;
    end
    if (!is_read(cmd)) begin
      chk(txn_done && !rsp_valid, (cmd == 2'd2) ? "R8" : "R9", "done without data",
          {30'd0, txn_done, rsp_valid}, 32'd2);
      if (cmd == 2'd3) mem_m[addr] = wd;
    end
    @(negedge clk);
    snp_flush = '0;
    if (is_read(cmd)) begin
      if (flusher >= 0 && flusher != src) begin
        exp_d = fd; exp_fc = 1'b1; mem_m[addr] = fd;
      end else begin
        exp_d = mem_m[addr]; exp_fc = 1'b0;
      end
      chk(rsp_valid && txn_done, "R5", "reply strobe", {30'd0, rsp_valid, txn_done}, 32'd3);
      chk(rsp_data == exp_d, exp_fc ? "R6" : ((flusher == src) ? "R7" : "R5"),
          "reply data", 32'(rsp_data), 32'(exp_d));
      chk(rsp_from_cache == exp_fc, exp_fc ? "R6" : "R7", "reply source",
          32'(rsp_from_cache), 32'(exp_fc));
      @(negedge clk);
    end else begin
      chk(!rsp_valid, (cmd == 2'd2) ? "R8" : "R9", "no reply strobe", 32'(rsp_valid), 32'd0);
    end
    chk(grant == '0, "R2", "grant released", 32'(grant), 32'd0);
  endtask

  // several caches request at once; check the service order
  task automatic rr_round(logic [N-1:0] mask);
    logic [N-1:0] pend = mask;
    int w;
    int e;
    @(negedge clk);
    for (int i = 0; i < N; i++) if (mask[i]) begin
      req_valid[i] = 1'b1;
      req_cmd[i*2 +: 2] = 2'd0;
      req_addr[i*AW +: AW] = AW'(i);
    end
    while (pend != '0) begin
      @(negedge clk);
      wait_grant();
      w = -1;
      for (int i = 0; i < N; i++) if (grant[i]) w = i;
      e = rr_next(last_srv, pend);
      chk(w == e, "R3", "round-robin winner", 32'(w), 32'(e));
      if (w < 0) break;
      req_valid[w] = 1'b0;
      pend[w] = 1'b0;
      last_srv = w;
      repeat (2) @(negedge clk);
      chk(rsp_valid && rsp_data == mem_m[w], "R5", "rr reply", 32'(rsp_data), 32'(mem_m[w]));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    chk(grant == '0 && !snp_valid && !rsp_valid && !txn_done, "R1", "outputs in reset",
        {grant, snp_valid, rsp_valid, txn_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grant == '0 && !snp_valid && !rsp_valid && !txn_done, "R1", "outputs after reset",
        {grant, snp_valid, rsp_valid, txn_done}, 32'd0);

    // R1: fresh memory reads zero
    do_txn(1, 2'd0, 5, 16'h0, -1, 16'h0);
    // R9: writeback then read back from memory
    do_txn(2, 2'd3, 5, 16'hBEEF, 0, 16'h1111);
    do_txn(0, 2'd0, 5, 16'h0, -1, 16'h0);
    // R6: intervention updates requester and memory
    do_txn(3, 2'd1, 9, 16'h0, 1, 16'hCAFE);
    do_txn(2, 2'd0, 9, 16'h0, -1, 16'h0);
    // R7: requester's own flush ignored
    do_txn(1, 2'd0, 9, 16'h0, 1, 16'h7777);
    // R8: upgrade with a stray flush leaves memory alone
    do_txn(0, 2'd2, 9, 16'h0, 3, 16'h5555);
    do_txn(0, 2'd0, 9, 16'h0, -1, 16'h0);

    // R3: simultaneous requests
    rr_round(4'b1111);
    rr_round(4'b1010);
    rr_round(4'b0101);
    rr_round(4'b1001);

    for (int n = 0; n < 80; n++) begin
      int src = int'($urandom % N);
      logic [1:0] cmd = 2'($urandom % 4);
      int addr = int'($urandom % 8);
      int fsel = int'($urandom % 6);
      do_txn(src, cmd, addr, 16'($urandom), (fsel < N) ? fsel : -1, 16'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule